// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave-side serial port. It gives an external host read and write access to a bank of 32 byte-wide registers. The host frames each transaction with an active-low chip select. Within the frame, the host sends a control byte and then moves one data byte, or a run of data bytes in burst mode. The register storage lives outside the block. The port presents a one-cycle read strobe and a one-cycle write strobe with an address and write data, and it takes read data back one cycle after the read strobe.

The block runs entirely on the system clock. It samples the chip select, serial clock and serial data lines through a synchronizer and turns the serial clock transitions into sample and drive events. Two static straps choose which serial clock transition samples input data and which transition updates output data. The straps work independently of each other. The serial clock half period must be at least four system clock periods.

Top module: `sreg_port`

## Requirements
- R1: The control byte is the first eight sampled bits. Bit 1 is the direction (1 = read, 0 = write). Bits 2 to 6 are the register address, least significant bit first.
- R2: Control bit 7 is reserved and has no effect on the transaction. Control bit 8 is the burst flag (1 = burst).
- R3: In a write, sampled bits 9 to 16 form the data byte, least significant bit first. After the sixteenth sample the port issues exactly one `reg_wr_o` pulse, one cycle long, carrying that address and byte.
- R4: In a read, the port pulses `reg_rd_o` with the address once the eighth bit is sampled. It captures `reg_rdata_i` on the following cycle. The byte is shifted out least significant bit first: bit 0 goes out on the first output transition after the eighth sample, and each later output transition drives the next bit.
- R5: With `in_edge_i` = 0, input data is sampled on the rising serial clock edge. With `in_edge_i` = 1, it is sampled on the falling edge.
- R6: With `out_edge_i` = 0, output data is updated on the falling serial clock edge. With `out_edge_i` = 1, it is updated on the rising edge.
- R7: `sdo_en_o` is high only during the data phase of a read while chip select is low. No write is issued while it is high.
- R8: In burst mode, the address increments after every data byte, wrapping from 31 to 0. This continues until chip select rises. A burst read fetches the next address as soon as the previous byte's last input bit has been sampled.
- R9: Outside burst mode, serial clocks beyond the sixteenth are ignored: they cause no further strobes.
- R10: Raising chip select before the sixteenth sample aborts the frame without a write. The next frame starts from a fresh control byte.
- R11: After reset, `sdo_o`, `sdo_en_o`, `reg_rd_o` and `reg_wr_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, frames a transaction |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| in_edge_i | input | 1 | Input sample edge select: 0 rising, 1 falling |
| out_edge_i | input | 1 | Output update edge select: 0 falling, 1 rising |
| sdo_o | output | 1 | Serial data to host |
| sdo_en_o | output | 1 | Output enable for the serial data pad |
| reg_rd_o | output | 1 | Register read strobe |
| reg_wr_o | output | 1 | Register write strobe |
| reg_addr_o | output | ADDR_W | Register address for the strobe |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_rdata_i | input | DATA_W | Register read data, valid one cycle after `reg_rd_o` |

## Verification
A bit counter that slips, or a phase that is wrong, first shows up on the register strobes. The strobe then fires a sample early or late, or carries an address or byte shifted by one bit position, and the per-clock strobe monitor catches it within a few system clocks of the sixteenth serial edge. A wrong edge selection or a mistimed output load shows up as a corrupted read-back byte within the same frame. A burst pointer that wraps wrongly shows up as a write landing in the wrong register, which the next read of that register exposes. A phase that persists after an abort shows up as a stray write strobe, or as a misframed control byte in the following transaction.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned ADDR_W_DEF = 5;
  localparam int unsigned DATA_W_DEF = 8;
  // direction, reserved and burst bits around the address
  localparam int unsigned CTL_EXTRA  = 3;
  typedef enum logic [1:0] {PH_CTL, PH_DATA, PH_DONE} phase_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sreg_edge.sv
module sreg_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic in_edge_i,
  input  logic out_edge_i,
  output logic act_o,
  output logic smp_o,
  output logic drv_o
);
  logic sclk_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise  = sclk_i & ~sclk_q;
  assign fall  = ~sclk_i & sclk_q;
  assign act_o = ~cs_ni;
  assign smp_o = act_o & (in_edge_i  ? fall : rise);
  assign drv_o = act_o & (out_edge_i ? rise : fall);
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              smp_i,
  input  logic              sdi_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_phase_o
);
  localparam int unsigned CTL_W   = ADDR_W + CTL_EXTRA;
  localparam int unsigned SH_W    = (CTL_W > DATA_W) ? CTL_W : DATA_W;
  localparam int unsigned CNT_W   = $clog2(SH_W);
  localparam int unsigned CTL_OFS = SH_W - CTL_W;
  localparam int unsigned DAT_OFS = SH_W - DATA_W;

  logic [SH_W-1:0]   sh_q, sh_nx;
  logic [CNT_W-1:0]  cnt_q;
  phase_e            ph_q;
  logic              dir_q, burst_q, last;
  logic [ADDR_W-1:0] ptr_q, ptr_inc;

  // bits arrive LSB first, so shift toward bit 0
  assign sh_nx   = {sdi_i, sh_q[SH_W-1:1]};
  assign last    = (ph_q == PH_CTL) ? (cnt_q == CNT_W'(CTL_W-1))
                                    : (cnt_q == CNT_W'(DATA_W-1));
  assign ptr_inc = ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      ph_q    <= PH_CTL;
      dir_q   <= 1'b0;
      burst_q <= 1'b0;
      ptr_q   <= '0;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      rd_o <= 1'b0;
      wr_o <= 1'b0;
      if (!act_i) begin
        ph_q  <= PH_CTL;
        cnt_q <= '0;
      end else if (smp_i && ph_q != PH_DONE) begin
        sh_q  <= sh_nx;
        cnt_q <= last ? '0 : cnt_q + 1'b1;
        if (last) begin
          if (ph_q == PH_CTL) begin
            dir_q   <= sh_nx[CTL_OFS];
            ptr_q   <= sh_nx[CTL_OFS+1 +: ADDR_W];
            burst_q <= sh_nx[SH_W-1];
            ph_q    <= PH_DATA;
            if (sh_nx[CTL_OFS]) begin
              rd_o   <= 1'b1;
              addr_o <= sh_nx[CTL_OFS+1 +: ADDR_W];
            end
          end else begin
            if (!dir_q) begin
              wr_o    <= 1'b1;
              addr_o  <= ptr_q;
              wdata_o <= sh_nx[DAT_OFS +: DATA_W];
            end
            if (burst_q) begin
              ptr_q <= ptr_inc;
              if (dir_q) begin
                rd_o   <= 1'b1;
                addr_o <= ptr_inc;
              end
            end else begin
              ph_q <= PH_DONE;
            end
          end
        end
      end
    end
  end

  assign rd_phase_o = act_i & dir_q & (ph_q != PH_CTL);
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              drv_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdo_o
);
  localparam int unsigned LEFT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [LEFT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      sdo_o  <= 1'b0;
    end else if (!act_i) begin
      left_q <= '0;
      sdo_o  <= 1'b0;
    end else begin
      if (drv_i && left_q != '0) begin
        sdo_o  <= sh_q[0];
        sh_q   <= sh_q >> 1;
        left_q <= left_q - 1'b1;
      end
      if (load_i) begin
        sh_q   <= data_i;
        left_q <= LEFT_W'(DATA_W);
      end
    end
  end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              in_edge_i,
  input  logic              out_edge_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic cs_s, sclk_s, sdi_s;
  logic act, smp, drv, rd_phase, load_q;

  sreg_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   ({cs_s, sclk_s, sdi_s})
  );

  sreg_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_s),
    .cs_ni     (cs_s),
    .in_edge_i (in_edge_i),
    .out_edge_i(out_edge_i),
    .act_o     (act),
    .smp_o     (smp),
    .drv_o     (drv)
  );

  sreg_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .smp_i     (smp),
    .sdi_i     (sdi_s),
    .rd_o      (reg_rd_o),
    .wr_o      (reg_wr_o),
    .addr_o    (reg_addr_o),
    .wdata_o   (reg_wdata_o),
    .rd_phase_o(rd_phase)
  );

  // read data returns one cycle after the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= reg_rd_o;
  end

  sreg_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (act),
    .drv_i (drv),
    .load_i(load_q),
    .data_i(reg_rdata_i),
    .sdo_o (sdo_o)
  );

  assign sdo_en_o = rd_phase;
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_rd_o,
  input logic              reg_wr_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              sdo_en_o
);
  logic              seen_q;
  logic [ADDR_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (!sdo_en_o) begin
      seen_q <= 1'b0;
    end else if (reg_rd_o) begin
      seen_q <= 1'b1;
      prev_q <= reg_addr_o;
    end
  end

  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) reg_wr_o |=> !reg_wr_o); // R3
  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(reg_rd_o && reg_wr_o)); // R3
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) reg_rd_o |=> !reg_rd_o); // R4
  AST_EN_START: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(sdo_en_o) |-> reg_rd_o); // R7
  AST_NO_WR_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni) reg_wr_o |-> !sdo_en_o); // R7
  AST_RD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o && seen_q) |-> reg_addr_o == ADDR_W'(prev_q + 1'b1)); // R8
endmodule

bind sreg_port sreg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_rd_o  (reg_rd_o),
  .reg_wr_o  (reg_wr_o),
  .reg_addr_o(reg_addr_o),
  .sdo_en_o  (sdo_en_o)
);

// File: tb/sreg_port_tb.sv
module sreg_port_tb;
  localparam int H = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, sdi = 1'b0, ices = 1'b0, oces = 1'b0;
  logic sdo_o, sdo_en_o, reg_rd_o, reg_wr_o;
  logic [4:0] reg_addr_o;
  logic [7:0] reg_wdata_o, rdata;
  logic [7:0] mem [32];
  logic [7:0] exp_mem [32];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  int n_chk = 0, n_fail = 0;
  int exp_wr_a[$], exp_wr_d[$], exp_rd_a[$];

  always #5 clk = ~clk;

  sreg_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .sdi_i(sdi),
    .in_edge_i(ices), .out_edge_i(oces), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o),
    .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(rdata)
  );

  // register bank outside the port, one-cycle read latency
  always @(posedge clk) begin
    if (reg_rd_o) rdata <= mem[reg_addr_o];
    if (reg_wr_o) mem[reg_addr_o] <= reg_wdata_o;
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // strobe monitor, every clock
  always @(negedge clk) begin
    if (rst_ni) begin
      if (reg_wr_o) begin
        if (exp_wr_a.size() == 0) chk_eq("R9 R10", "unexpected write addr", int'(reg_addr_o), -1);
        else begin
          chk_eq("R3", "write addr", int'(reg_addr_o), exp_wr_a.pop_front());
          chk_eq("R3", "write data", int'(reg_wdata_o), exp_wr_d.pop_front());
        end
      end
      if (reg_rd_o) begin
        if (exp_rd_a.size() == 0) chk_eq("R9 R10", "unexpected read addr", int'(reg_addr_o), -1);
        else chk_eq("R4", "read addr", int'(reg_addr_o), exp_rd_a.pop_front());
      end
    end
  end

  function automatic bit frame_bit(int s, bit rd, logic [4:0] a, bit rsv, bit burst);
    if (s == 1) return rd;
    if (s <= 6) return a[s-2];
    if (s == 7) return rsv;
    if (s == 8) return burst;
    if (rd) return 1'b0;
    return wbuf[((s-9)/8)%8][(s-9)%8];
  endfunction

  task automatic xfer(input bit rd, input logic [4:0] a, input bit burst, input bit rsv,
                      input int nclk, input bit ie, input bit oe, input string tag);
    logic [7:0] snap [8];
    logic [4:0] cur = a;
    int s = 0, loadno = 0, pend_byte = 0, cb = 0, cbit = 0, nread;
    bit load_pend = 0, have = 0;
    for (int b = 0; b < 8; b++) begin
      snap[b] = exp_mem[5'(a + b)];
      rbuf[b] = 8'h00;
    end
    ices = ie;
    oces = oe;
    sdi = frame_bit(1, rd, a, rsv, burst);
    repeat (H) @(negedge clk);
    cs_ni = 1'b0;
    repeat (H) @(negedge clk);
    for (int e = 0; e < 2*nclk; e++) begin
      bit rising = (e % 2 == 0);
      bit is_s = rising ? !ie : ie;
      bit is_o = rising ? oe : !oe;
      if (is_o) begin
        if (rd) begin
          if (have) begin
            rbuf[cb%8][cbit] = sdo_o;
            chk_eq("R7", "sdo_en in read data phase", int'(sdo_en_o), 1);
          end
          if (load_pend) begin
            have = 1; cb = pend_byte; cbit = 0; load_pend = 0;
          end else if (have && cbit < 7) cbit++;
          else have = 0;
        end else begin
          chk_eq("R7", "sdo_en in write frame", int'(sdo_en_o), 0);
        end
      end
      sclk = rising;
      if (is_s) begin
        s++;
        if (s == 8) begin
          if (rd) begin
            exp_rd_a.push_back(int'(cur));
            load_pend = 1; pend_byte = 0; loadno = 1;
          end
        end else if (s > 8 && s % 8 == 0) begin
          int b = (s - 16) / 8;
          if (b == 0 || burst) begin
            if (!rd) begin
              exp_wr_a.push_back(int'(cur));
              exp_wr_d.push_back(int'(wbuf[b%8]));
              exp_mem[cur] = wbuf[b%8];
            end
            if (burst) begin
              cur = cur + 5'd1;
              if (rd) begin
                exp_rd_a.push_back(int'(cur));
                load_pend = 1; pend_byte = loadno; loadno++;
              end
            end
          end
        end
      end else begin
        sdi = frame_bit(s + 1, rd, a, rsv, burst);
      end
      repeat (H) @(negedge clk);
    end
    if (rd && have) rbuf[cb%8][cbit] = sdo_o;
    cs_ni = 1'b1;
    repeat (H) @(negedge clk);
    chk_eq("R7", "sdo_en after frame", int'(sdo_en_o), 0);
    if (rd && nclk >= 16) begin
      nread = burst ? (nclk - 8) / 8 : 1;
      for (int b = 0; b < nread; b++)
        chk_eq(tag, $sformatf("read byte %0d", b), int'(rbuf[b]), int'(snap[b]));
    end
    repeat (H) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i] = 8'(i * 7 + 1);
      exp_mem[i] = 8'(i * 7 + 1);
    end
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R11", "sdo after reset", int'(sdo_o), 0);
    chk_eq("R11", "sdo_en after reset", int'(sdo_en_o), 0);
    chk_eq("R11", "rd strobe after reset", int'(reg_rd_o), 0);
    chk_eq("R11", "wr strobe after reset", int'(reg_wr_o), 0);

    // basic write and read, rising sample / falling drive
    wbuf[0] = 8'hA5;
    xfer(0, 5'd5, 0, 0, 16, 0, 0, "R1 R3");
    xfer(1, 5'd5, 0, 0, 16, 0, 0, "R1 R4");
    // sample on falling edge
    wbuf[0] = 8'h3C;
    xfer(0, 5'd31, 0, 0, 16, 1, 0, "R5");
    xfer(1, 5'd31, 0, 0, 16, 1, 0, "R5");
    // drive on rising edge
    wbuf[0] = 8'hC3;
    xfer(0, 5'd16, 0, 0, 16, 0, 1, "R6");
    xfer(1, 5'd16, 0, 0, 16, 0, 1, "R6");
    // both inverted
    wbuf[0] = 8'h81;
    xfer(0, 5'd1, 0, 0, 16, 1, 1, "R5 R6");
    xfer(1, 5'd1, 0, 0, 16, 1, 1, "R5 R6");
    // reserved bit set has no effect
    wbuf[0] = 8'h5A;
    xfer(0, 5'd2, 0, 1, 16, 0, 0, "R2");
    xfer(1, 5'd2, 0, 1, 16, 0, 0, "R2");
    // burst write across the wrap, then burst reads in two edge modes
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer(0, 5'd30, 1, 0, 32, 0, 0, "R8");
    xfer(1, 5'd30, 1, 0, 32, 0, 0, "R8");
    xfer(1, 5'd29, 1, 0, 40, 1, 1, "R8");
    // extra clocks without burst
    wbuf[0] = 8'h96; wbuf[1] = 8'hFF; wbuf[2] = 8'hEE;
    xfer(0, 5'd9, 0, 0, 32, 0, 0, "R9");
    xfer(1, 5'd9, 0, 0, 16, 0, 0, "R9");
    xfer(1, 5'd10, 0, 0, 16, 0, 0, "R9");
    xfer(1, 5'd12, 0, 0, 28, 0, 1, "R9");
    // abort mid data phase, then a clean frame
    wbuf[0] = 8'h00;
    xfer(0, 5'd7, 0, 0, 12, 0, 0, "R10");
    xfer(1, 5'd7, 0, 0, 16, 0, 0, "R10");
    xfer(1, 5'd7, 0, 0, 5, 0, 0, "R10");
    xfer(1, 5'd6, 0, 0, 16, 0, 0, "R10");

    repeat (10) @(negedge clk);
    chk_eq("R9 R10", "pending writes", exp_wr_a.size(), 0);
    chk_eq("R4", "pending reads", exp_rd_a.size(), 0);
    report();
    $finish;
  end
endmodule